// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block is a bank of hardware semaphores. Several processors on one chip use it to take turns on shared resources. Each processor reaches the bank through its own register port. Every access on a port carries a 4-bit master tag. A master claims a semaphore by writing its own tag value into that semaphore's register. It then reads the register back: it owns the semaphore exactly when the low four bits it reads equal its own tag. The owner gives the semaphore back by writing zero. An owner value of zero means free, so tag 0 can never own a semaphore.

A control register at offset 0x00 selects the protocol. With bit 0 clear, the claim-by-ID-write protocol described here is active. With bit 0 set, the bank is handed to another protocol that is not built here, and the semaphore states are frozen. Offset 0x90 is the bulk interrupt-clear register. Software writes 0xFFFF there during setup and teardown. No interrupt sources exist in this block, so that write changes nothing and the register reads as zero.

Top module: `hsem_bank`

## Requirements
- R1: After reset every semaphore reads 0 (free) and the control register reads 0.
- R2: Semaphore i sits at byte offset 0x08 + 4*i, for i from 0 to 31. It reads back as the owner tag in bits [3:0], with bits [31:4] zero.
- R3: A write to a free semaphore whose data equals the zero-extended master tag of that port stores the tag as owner, provided the tag is nonzero.
- R4: A claim write to a semaphore held by some tag leaves the stored owner unchanged.
- R5: A write of 0 to a semaphore from a port whose master tag equals the current owner frees the semaphore.
- R6: A write of 0 from a port whose tag differs from the owner leaves the semaphore held.
- R7: When two ports claim the same free semaphore in the same cycle, the lower-numbered port becomes the owner.
- R8: The control register at offset 0x00 is read/write. While its bit 0 is 1, every semaphore write is ignored. When bit 0 is 0 again, claims work as normal. If two ports write it in the same cycle, the lower-numbered port's data is kept.
- R9: A write of 0xFFFF to offset 0x90 (interrupt clear) changes no semaphore and not the control register, and offset 0x90 reads 0.
- R10: Offsets outside the control register and the semaphore array read 0, and writes to them change nothing. This includes misaligned offsets such as 0x09 and the offset 0x88 just past semaphore 31.
- R11: Read data is registered. It appears after the clock edge at which read enable is high. It shows the state before any write at that same edge, and it holds while read enable is low.
- R12: A write of nonzero data that differs from the port's zero-extended tag is ignored. Any write from a port with tag 0 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | NUM_PORT*ADDR_W | Byte address per port, port p at [p*ADDR_W +: ADDR_W] |
| busWe | input | NUM_PORT | Write enable per port |
| busWdata | input | NUM_PORT*32 | Write data per port |
| busRe | input | NUM_PORT | Read enable per port |
| busMid | input | NUM_PORT*4 | Master tag of the access on each port |
| busRdata | output | NUM_PORT*32 | Registered read data per port |

## Verification
The hardest cases to reach are same-cycle collisions. The first is two ports claiming one free semaphore on the same edge. The second is a read that coincides with a write to the same semaphore. The bench drives both ports from one task at the same falling edge, so both accesses meet at one rising edge. It then reads the result back at later, separate edges, which shows who won and that the coinciding read returned the state from before the write. Frozen operation is reached by setting the protocol bit and then issuing claims and owner releases that would otherwise succeed.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int IDX_W  = 8;

  // per-port strobes from decode to datapath
  typedef struct packed {
    logic              semWr;
    logic              ctrlWr;
    logic              rdEn;
    logic              rdSem;
    logic              rdCtrl;
    logic [IDX_W-1:0]  semIdx;
    logic [ID_W-1:0]   mid;
    logic [DATA_W-1:0] wdata;
  } portStb_t;
endpackage

// File: rtl/hsem_ctrl.sv
module hsem_ctrl
  import hsem_pkg::*;
#(
  parameter int NUM_SEM  = 32,
  parameter int NUM_PORT = 2,
  parameter int ADDR_W   = 8
) (
  input  logic [NUM_PORT*ADDR_W-1:0] busAddr,
  input  logic [NUM_PORT-1:0]        busWe,
  input  logic [NUM_PORT*DATA_W-1:0] busWdata,
  input  logic [NUM_PORT-1:0]        busRe,
  input  logic [NUM_PORT*ID_W-1:0]   busMid,
  output portStb_t                   stb [NUM_PORT]
);
  localparam logic [31:0] SEM_BASE = 32'h8;
  localparam logic [31:0] SEM_END  = SEM_BASE + 32'(4 * NUM_SEM);
  localparam logic [31:0] CTRL_OFF = 32'h0;

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    logic [31:0] addrExt;
    logic [31:0] semOff;
    logic        isSem;
    logic        isCtrl;

    assign addrExt = 32'(busAddr[p*ADDR_W +: ADDR_W]);
    assign semOff  = addrExt - SEM_BASE;
    assign isSem   = (addrExt >= SEM_BASE) && (addrExt < SEM_END) && (addrExt[1:0] == 2'b00);
    assign isCtrl  = (addrExt == CTRL_OFF);

    always_comb begin
      stb[p].semWr  = busWe[p] & isSem;
      stb[p].ctrlWr = busWe[p] & isCtrl;
      stb[p].rdEn   = busRe[p];
      stb[p].rdSem  = isSem;
      stb[p].rdCtrl = isCtrl;
      stb[p].semIdx = semOff[IDX_W+1:2];
      stb[p].mid    = busMid[p*ID_W +: ID_W];
      stb[p].wdata  = busWdata[p*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/hsem_dp.sv
module hsem_dp
  import hsem_pkg::*;
#(
  parameter int NUM_SEM  = 32,
  parameter int NUM_PORT = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  portStb_t                   stb [NUM_PORT],
  output logic [NUM_PORT*DATA_W-1:0] busRdata,
  output logic [NUM_SEM*ID_W-1:0]    ownerFlat,
  output logic                       protoSel
);
  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] ctrlNxt;

  assign protoSel = ctrlQ[0];

  // control register: lower port wins by being applied last
  always_comb begin
    ctrlNxt = ctrlQ;
    for (int p = NUM_PORT - 1; p >= 0; p--) begin
      if (stb[p].ctrlWr) ctrlNxt = stb[p].wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNxt;
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    logic [ID_W-1:0] ownQ;
    logic [ID_W-1:0] ownNxt;
    logic            relHit;

    always_comb begin
      relHit = 1'b0;
      ownNxt = ownQ;
      if (!ctrlQ[0]) begin
        for (int p = 0; p < NUM_PORT; p++) begin
          if (stb[p].semWr && stb[p].semIdx == IDX_W'(s) && stb[p].wdata == '0
              && ownQ != '0 && stb[p].mid == ownQ)
            relHit = 1'b1;
        end
        if (relHit) begin
          ownNxt = '0;
        end else if (ownQ == '0) begin
          for (int p = NUM_PORT - 1; p >= 0; p--) begin
            if (stb[p].semWr && stb[p].semIdx == IDX_W'(s) && stb[p].mid != '0
                && stb[p].wdata == DATA_W'(stb[p].mid))
              ownNxt = stb[p].mid;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ownQ <= '0;
      else       ownQ <= ownNxt;
    end

    assign ownerFlat[s*ID_W +: ID_W] = ownQ;
  end

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_rd
    logic [DATA_W-1:0] rdQ;
    logic [DATA_W-1:0] rdVal;

    always_comb begin
      if (stb[p].rdCtrl)     rdVal = ctrlQ;
      else if (stb[p].rdSem) rdVal = DATA_W'(ownerFlat[32'(stb[p].semIdx) * ID_W +: ID_W]);
      else                   rdVal = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           rdQ <= '0;
      else if (stb[p].rdEn) rdQ <= rdVal;
    end

    assign busRdata[p*DATA_W +: DATA_W] = rdQ;
  end
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank #(
  parameter int NUM_SEM  = 32,
  parameter int NUM_PORT = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PORT*ADDR_W-1:0] busAddr,
  input  logic [NUM_PORT-1:0]    busWe,
  input  logic [NUM_PORT*32-1:0] busWdata,
  input  logic [NUM_PORT-1:0]    busRe,
  input  logic [NUM_PORT*4-1:0]  busMid,
  output logic [NUM_PORT*32-1:0] busRdata
);
  hsem_pkg::portStb_t stb [NUM_PORT];
  logic [NUM_SEM*4-1:0] ownerFlat;
  logic                 protoSel;

  hsem_ctrl #(.NUM_SEM(NUM_SEM), .NUM_PORT(NUM_PORT), .ADDR_W(ADDR_W)) uCtrl (
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRe    (busRe),
    .busMid   (busMid),
    .stb      (stb)
  );

  hsem_dp #(.NUM_SEM(NUM_SEM), .NUM_PORT(NUM_PORT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busRdata  (busRdata),
    .ownerFlat (ownerFlat),
    .protoSel  (protoSel)
  );
endmodule

// File: rtl/hsem_chk.sv
module hsem_chk #(
  parameter int NUM_SEM  = 32,
  parameter int NUM_PORT = 2,
  parameter int ADDR_W   = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_PORT*ADDR_W-1:0] busAddr,
  input logic [NUM_PORT-1:0]        busRe,
  input logic [NUM_PORT*32-1:0]     busRdata,
  input logic [NUM_SEM*4-1:0]       ownerFlat,
  input logic                       protoSel
);
  for (genvar p = 0; p < NUM_PORT; p++) begin : g_p
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (busRe[p] && busAddr[p*ADDR_W +: ADDR_W] != '0) |=> busRdata[p*32+4 +: 28] == '0); // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !busRe[p] |=> $stable(busRdata[p*32 +: 32])); // R11
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_s
    AST_NO_TAKEOVER: assert property (@(posedge clk) disable iff (!rstN)
      ownerFlat[s*4 +: 4] != 4'd0 |=>
        (ownerFlat[s*4 +: 4] == $past(ownerFlat[s*4 +: 4]) || ownerFlat[s*4 +: 4] == 4'd0)); // R4
  end

  AST_FROZEN_BANK: assert property (@(posedge clk) disable iff (!rstN)
    protoSel |=> $stable(ownerFlat)); // R8
endmodule

bind hsem_bank hsem_chk #(.NUM_SEM(NUM_SEM), .NUM_PORT(NUM_PORT), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRe     (busRe),
  .busRdata  (busRdata),
  .ownerFlat (ownerFlat),
  .protoSel  (protoSel)
);

// File: tb/sim_hsem_bank.sv
`timescale 1ns/100ps
module sim_hsem_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  addr [2];
  logic        we [2];
  logic        re [2];
  logic [31:0] wdat [2];
  logic [3:0]  mid [2];
  logic [15:0] busAddr;
  logic [1:0]  busWe, busRe;
  logic [63:0] busWdata, busRdata;
  logic [7:0]  busMid;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign busAddr  = {addr[1], addr[0]};
  assign busWe    = {we[1], we[0]};
  assign busRe    = {re[1], re[0]};
  assign busWdata = {wdat[1], wdat[0]};
  assign busMid   = {mid[1], mid[0]};

  hsem_bank u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busMid(busMid), .busRdata(busRdata)
  );

  function automatic logic [7:0] semAddr(int i);
    return 8'(8 + 4 * i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int p = 0; p < 2; p++) begin
      addr[p] = '0; we[p] = 0; re[p] = 0; wdat[p] = '0; mid[p] = '0;
    end
  endtask

  task automatic setPort(int p, bit w, bit r, logic [7:0] a, logic [31:0] d, logic [3:0] m);
    addr[p] = a; we[p] = w; re[p] = r; wdat[p] = d; mid[p] = m;
  endtask

  task automatic wr(int p, logic [7:0] a, logic [31:0] d, logic [3:0] m);
    @(negedge clk); setPort(p, 1, 0, a, d, m);
    @(negedge clk); clearAll();
  endtask

  task automatic rd(int p, logic [7:0] a, output logic [31:0] v);
    @(negedge clk); setPort(p, 0, 1, a, '0, 4'd1);
    @(negedge clk); clearAll();
    v = busRdata[p*32 +: 32];
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(0, 8'h00, v); chk("R1 ctrl after reset", v, 0);
    rd(0, semAddr(0), v); chk("R1 sem0 after reset", v, 0);
    rd(1, semAddr(31), v); chk("R1 sem31 after reset", v, 0);
  endtask

  task automatic tClaim();
    logic [31:0] v;
    wr(0, semAddr(3), 32'd1, 4'd1);
    rd(0, semAddr(3), v); chk("R3 claim sem3 by tag1", v, 32'd1);
    rd(1, semAddr(3), v); chk("R2 sem3 seen from port1", v, 32'd1);
  endtask

  task automatic tContend();
    logic [31:0] v;
    wr(1, semAddr(3), 32'd2, 4'd2);
    rd(1, semAddr(3), v); chk("R4 foreign claim ignored", v, 32'd1);
    wr(1, semAddr(3), 32'd0, 4'd2);
    rd(1, semAddr(3), v); chk("R6 foreign release ignored", v, 32'd1);
    wr(0, semAddr(3), 32'd0, 4'd1);
    rd(0, semAddr(3), v); chk("R5 owner release frees", v, 32'd0);
    wr(1, semAddr(3), 32'd2, 4'd2);
    rd(0, semAddr(3), v); chk("R3 reclaim by tag2", v, 32'd2);
  endtask

  task automatic tBadClaim();
    logic [31:0] v;
    wr(0, semAddr(7), 32'd5, 4'd3);
    rd(0, semAddr(7), v); chk("R12 data/tag mismatch ignored", v, 0);
    wr(0, semAddr(7), 32'h13, 4'd3);
    rd(0, semAddr(7), v); chk("R12 upper data bits mismatch ignored", v, 0);
    wr(1, semAddr(7), 32'd0, 4'd0);
    rd(1, semAddr(7), v); chk("R12 tag0 write ignored", v, 0);
  endtask

  task automatic tSimul();
    logic [31:0] v;
    @(negedge clk);
    setPort(0, 1, 0, semAddr(10), 32'd4, 4'd4);
    setPort(1, 1, 0, semAddr(10), 32'd6, 4'd6);
    @(negedge clk); clearAll();
    rd(1, semAddr(10), v); chk("R7 lower port wins", v, 32'd4);
    @(negedge clk);
    setPort(0, 1, 0, 8'h00, 32'hA0, 4'd1);
    setPort(1, 1, 0, 8'h00, 32'hB0, 4'd2);
    @(negedge clk); clearAll();
    rd(0, 8'h00, v); chk("R8 ctrl same-cycle lower port wins", v, 32'hA0);
    wr(0, 8'h00, 32'd0, 4'd1);
    wr(0, semAddr(31), 32'd9, 4'd9);
    rd(0, semAddr(31), v); chk("R2 last semaphore at 0x84", v, 32'd9);
    wr(0, 8'h88, 32'd9, 4'd9);
    rd(0, 8'h88, v); chk("R10 offset past array reads 0", v, 0);
  endtask

  task automatic tCtrl();
    logic [31:0] v;
    wr(0, 8'h00, 32'd1, 4'd1);
    rd(0, 8'h00, v); chk("R8 ctrl readback", v, 32'd1);
    wr(0, semAddr(5), 32'd1, 4'd1);
    rd(0, semAddr(5), v); chk("R8 claim frozen", v, 0);
    wr(0, semAddr(10), 32'd0, 4'd4);
    rd(0, semAddr(10), v); chk("R8 release frozen", v, 32'd4);
    wr(0, 8'h00, 32'd0, 4'd1);
    wr(0, semAddr(5), 32'd1, 4'd1);
    rd(0, semAddr(5), v); chk("R8 claim after unfreeze", v, 32'd1);
  endtask

  task automatic tIclr();
    logic [31:0] v;
    wr(0, 8'h90, 32'hFFFF, 4'd1);
    rd(0, 8'h90, v); chk("R9 iclr reads 0", v, 0);
    rd(0, 8'h00, v); chk("R9 ctrl untouched", v, 0);
    rd(1, semAddr(10), v); chk("R9 sem10 untouched", v, 32'd4);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    wr(0, 8'h04, 32'd1, 4'd1);
    rd(0, 8'h04, v); chk("R10 offset 0x04 reads 0", v, 0);
    wr(0, 8'h09, 32'd1, 4'd1);
    rd(0, 8'h09, v); chk("R10 misaligned reads 0", v, 0);
    rd(0, semAddr(0), v); chk("R10 sem0 untouched by 0x09 write", v, 0);
  endtask

  task automatic tRdTiming();
    logic [31:0] v;
    @(negedge clk);
    setPort(0, 1, 0, semAddr(20), 32'd1, 4'd1);
    setPort(1, 0, 1, semAddr(20), '0, 4'd2);
    @(negedge clk); clearAll();
    chk("R11 read shows pre-write state", busRdata[63:32], 0);
    repeat (3) @(negedge clk);
    chk("R11 read data held", busRdata[63:32], 0);
    rd(1, semAddr(20), v); chk("R11 later read shows owner", v, 32'd1);
  endtask

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 rdata at reset", busRdata, 0);
    tReset();
    tClaim();
    tContend();
    tBadClaim();
    tSimul();
    tCtrl();
    tIclr();
    tUnmapped();
    tRdTiming();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule